// File: doc/BRIEF.md
# Edge Interrupt Acknowledgement Tracker

This block follows one special edge-triggered interrupt source, typically a periodic timer, and remembers which receiving destinations still owe an end-of-interrupt (EOI) for the last edge delivered. While any acknowledgement is outstanding, fresh edges from the source are flagged as coalesced rather than sent again. Software can use that flag to correct for lost ticks, which keeps the receivers' sense of time from drifting.

Destination matching and message transport live outside. Upstream, a delivery stage reports which destinations an edge reached, the vector it carried, and a signed count of deliveries made. Each destination reports its EOIs as an index and a vector. The tracker keeps one outstanding bit and one recorded vector per destination, plus a pending count. The bookkeeping can lose consistency when a reported count is lower than the number of destinations actually reached. An EOI that would then take the count below zero makes the tracker rebuild its state from a live snapshot of which destinations still hold the vector pending.

Top module: `ack_tracker`

## Requirements
- R1: While reset is asserted, the pending count becomes 0 and every outstanding bit is cleared.
- R2: `req_coalesced` is 1 exactly when `req_valid` is 1 and the pending count is nonzero. `req_deliver` is 1 exactly when `req_valid` is 1 and the count is 0. Both are combinational in the same cycle.
- R3: A delivery report with `dlv_valid` high is taken while the count is 0. On the next edge, the outstanding map equals `dlv_map`, each destination in it records `dlv_vector`, and the count is loaded with `dlv_count`. `dlv_count` is 6-bit two's complement.
- R4: A delivery report arriving while the count is nonzero changes neither the count nor the outstanding map.
- R5: An EOI whose destination bit is set and whose vector equals that destination's recorded vector clears the bit and lowers the count by one on the next edge.
- R6: An EOI for a destination whose bit is clear, or carrying a different vector, has no effect. A second EOI from the same destination therefore never lowers the count twice.
- R7: When `dlv_valid` and `eoi_valid` are high in the same cycle, the EOI is discarded and only the delivery report is considered.
- R8: A matching EOI that arrives while the count is 0 triggers a rebuild on the next edge. The outstanding map becomes `live_pend`, the count becomes the number of ones in `live_pend`, and each destination in it records the vector of the last accepted delivery.
- R9: A negative `dlv_count` loads a count of 0 and clears the outstanding map. A value above the number of destinations loads that number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New edge request from the source |
| req_coalesced | output | 1 | Request refused: an acknowledgement is still owed |
| req_deliver | output | 1 | Request may be delivered |
| dlv_valid | input | 1 | Delivery report present |
| dlv_map | input | 16 | Destinations reached by the delivery |
| dlv_vector | input | 8 | Vector sent |
| dlv_count | input | 6 | Signed delivery result count |
| eoi_valid | input | 1 | EOI report present |
| eoi_dest | input | 4 | Index of the acknowledging destination |
| eoi_vector | input | 8 | Vector being acknowledged |
| live_pend | input | 16 | Destinations currently holding the tracked vector pending (used on rebuild) |
| pend_count | output | 5 | Current pending count |
| owed_map | output | 16 | Current outstanding bitmap |

## Verification
The coalesce and deliver flags follow the pending count in the same cycle as `req_valid`. They are checked about 1 ns after the request is driven, with no clock edge in between. Delivery reports, EOIs and rebuilds pass through one register stage. Their effect on `pend_count` and `owed_map` is therefore due at the first rising edge after the inputs are driven. The bench drives each input 1 ns after an edge, advances exactly one edge, and samples 1 ns later. Recorded vectors are visible only through later EOIs, so they are checked by whether a follow-up EOI is accepted.

// File: rtl/ack_trk_pkg.sv
package ack_trk_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_DELIVER = 2'd1,
        ACT_ACK     = 2'd2,
        ACT_REBUILD = 2'd3
    } ack_act_e;

endpackage

// File: rtl/ack_popcount.sv
module ack_popcount #(
    parameter int WIDTH = 16,
    parameter int CW    = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] bits,
    output logic [CW-1:0]    ones
);

    always_comb begin
        ones = '0;
        for (int i = 0; i < WIDTH; i++) begin
            ones = ones + CW'(bits[i]);
        end
    end

endmodule

// File: rtl/ack_vec_bank.sv
module ack_vec_bank #(
    parameter int NUM_DEST = 16,
    parameter int VEC_W    = 8,
    parameter int IW       = $clog2(NUM_DEST)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DEST-1:0] wr_mask,
    input  logic [VEC_W-1:0]    wr_vec,
    input  logic [IW-1:0]       rd_idx,
    input  logic [VEC_W-1:0]    cmp_vec,
    output logic                hit
);

    logic [VEC_W-1:0] vec_d [NUM_DEST];
    logic [VEC_W-1:0] vec_q [NUM_DEST];

    for (genvar g = 0; g < NUM_DEST; g++) begin : g_slot
        always_comb begin
            vec_d[g] = wr_mask[g] ? wr_vec : vec_q[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q[g] <= '0;
            end else begin
                vec_q[g] <= vec_d[g];
            end
        end
    end

    assign hit = (vec_q[rd_idx] == cmp_vec);

endmodule

// File: rtl/ack_tracker.sv
module ack_tracker #(
    parameter int NUM_DEST = 16,
    parameter int VEC_W    = 8,
    parameter int IW       = $clog2(NUM_DEST),
    parameter int CW       = $clog2(NUM_DEST + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_coalesced,
    output logic                req_deliver,
    input  logic                dlv_valid,
    input  logic [NUM_DEST-1:0] dlv_map,
    input  logic [VEC_W-1:0]    dlv_vector,
    input  logic [CW:0]         dlv_count,
    input  logic                eoi_valid,
    input  logic [IW-1:0]       eoi_dest,
    input  logic [VEC_W-1:0]    eoi_vector,
    input  logic [NUM_DEST-1:0] live_pend,
    output logic [CW-1:0]       pend_count,
    output logic [NUM_DEST-1:0] owed_map
);
    import ack_trk_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = CW'(NUM_DEST);

    typedef struct packed {
        logic [NUM_DEST-1:0] owed;
        logic [CW-1:0]       cnt;
        logic [VEC_W-1:0]    last_vec;
    } trk_state_t;

    trk_state_t          st_d, st_q;
    ack_act_e            act;
    logic                vec_hit;
    logic [NUM_DEST-1:0] wr_mask;
    logic [VEC_W-1:0]    wr_vec;
    logic [CW-1:0]       live_ones;
    logic [CW-1:0]       dlv_clamped;
    logic                dlv_neg;

    ack_vec_bank #(
        .NUM_DEST (NUM_DEST),
        .VEC_W    (VEC_W),
        .IW       (IW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_vec  (wr_vec),
        .rd_idx  (eoi_dest),
        .cmp_vec (eoi_vector),
        .hit     (vec_hit)
    );

    ack_popcount #(
        .WIDTH (NUM_DEST),
        .CW    (CW)
    ) u_pop (
        .bits (live_pend),
        .ones (live_ones)
    );

    always_comb begin
        dlv_neg = dlv_count[CW];
        if (dlv_neg) begin
            dlv_clamped = '0;
        end else if (dlv_count[CW-1:0] > CNT_MAX) begin
            dlv_clamped = CNT_MAX;
        end else begin
            dlv_clamped = dlv_count[CW-1:0];
        end
    end

    always_comb begin
        act = ACT_IDLE;
        if (dlv_valid) begin
            if (st_q.cnt == '0) begin
                act = ACT_DELIVER;
            end
        end else if (eoi_valid && st_q.owed[eoi_dest] && vec_hit) begin
            act = (st_q.cnt == '0) ? ACT_REBUILD : ACT_ACK;
        end
    end

    always_comb begin
        st_d    = st_q;
        wr_mask = '0;
        wr_vec  = st_q.last_vec;
        unique case (act)
            ACT_DELIVER: begin
                if (dlv_neg) begin
                    st_d.owed = '0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.owed     = dlv_map;
                    st_d.cnt      = dlv_clamped;
                    st_d.last_vec = dlv_vector;
                    wr_mask       = dlv_map;
                    wr_vec        = dlv_vector;
                end
            end
            ACT_ACK: begin
                st_d.owed[eoi_dest] = 1'b0;
                st_d.cnt            = st_q.cnt - CW'(1);
            end
            ACT_REBUILD: begin
                st_d.owed = live_pend;
                st_d.cnt  = live_ones;
                wr_mask   = live_pend;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_coalesced = req_valid && (st_q.cnt != '0);
    assign req_deliver   = req_valid && (st_q.cnt == '0);
    assign pend_count    = st_q.cnt;
    assign owed_map      = st_q.owed;

endmodule

// File: rtl/ack_tracker_chk.sv
module ack_tracker_chk #(
    parameter int NUM_DEST = 16,
    parameter int IW       = $clog2(NUM_DEST),
    parameter int CW       = $clog2(NUM_DEST + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_coalesced,
    input logic                req_deliver,
    input logic                dlv_valid,
    input logic                eoi_valid,
    input logic [CW-1:0]       pend_count,
    input logic [NUM_DEST-1:0] owed_map
);

    // R2
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_coalesced, req_deliver}));

    // R2
    flag_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_coalesced || req_deliver));

    // R4
    busy_dlv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && pend_count != '0) |=> ($stable(pend_count) && $stable(owed_map)));

    // R5
    ack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !dlv_valid && pend_count != '0) |=>
        (pend_count == $past(pend_count) || pend_count == $past(pend_count) - CW'(1)));

    // R6
    ack_no_new_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !dlv_valid && pend_count != '0) |=> ((owed_map & ~$past(owed_map)) == '0));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_count <= CW'(NUM_DEST));

endmodule

bind ack_tracker ack_tracker_chk #(
    .NUM_DEST (NUM_DEST),
    .IW       (IW),
    .CW       (CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_coalesced (req_coalesced),
    .req_deliver   (req_deliver),
    .dlv_valid     (dlv_valid),
    .eoi_valid     (eoi_valid),
    .pend_count    (pend_count),
    .owed_map      (owed_map)
);

// File: tb/sim_ack_tracker.sv
`timescale 1ns/1ps
module sim_ack_tracker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_coalesced, req_deliver;
    logic        dlv_valid;
    logic [15:0] dlv_map;
    logic [7:0]  dlv_vector;
    logic [5:0]  dlv_count;
    logic        eoi_valid;
    logic [3:0]  eoi_dest;
    logic [7:0]  eoi_vector;
    logic [15:0] live_pend;
    logic [4:0]  pend_count;
    logic [15:0] owed_map;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ack_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_coalesced(req_coalesced), .req_deliver(req_deliver),
        .dlv_valid(dlv_valid), .dlv_map(dlv_map), .dlv_vector(dlv_vector), .dlv_count(dlv_count),
        .eoi_valid(eoi_valid), .eoi_dest(eoi_dest), .eoi_vector(eoi_vector),
        .live_pend(live_pend), .pend_count(pend_count), .owed_map(owed_map)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        req_valid = 0; dlv_valid = 0; eoi_valid = 0;
        dlv_map = '0; dlv_vector = '0; dlv_count = '0;
        eoi_dest = '0; eoi_vector = '0; live_pend = '0;
    endtask

    task automatic deliver(input logic [15:0] m, input logic [7:0] v, input logic [5:0] c);
        dlv_valid = 1; dlv_map = m; dlv_vector = v; dlv_count = c;
        tick();
        dlv_valid = 0;
    endtask

    task automatic eoi(input logic [3:0] d, input logic [7:0] v);
        eoi_valid = 1; eoi_dest = d; eoi_vector = v;
        tick();
        eoi_valid = 0;
    endtask

    task automatic check_state(input string req, input logic [4:0] c, input logic [15:0] m);
        chk({req, " count"}, 32'(pend_count), 32'(c));
        chk({req, " map"}, 32'(owed_map), 32'(m));
    endtask

    task automatic check_req(input string req, input logic coal, input logic dlv);
        req_valid = 1;
        #1;
        chk({req, " coalesced"}, 32'(req_coalesced), 32'(coal));
        chk({req, " deliver"}, 32'(req_deliver), 32'(dlv));
        req_valid = 0;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        tick();
        tick();
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        check_state("R1 reset", 5'd0, 16'h0000);
        check_req("R2 idle req", 1'b0, 1'b1);
        #1;
        chk("R2 no req flags", 32'({req_coalesced, req_deliver}), 32'd0);
    endtask

    task automatic t_delivery_and_acks();
        deliver(16'h0013, 8'h41, 6'd3);
        check_state("R3 delivery load", 5'd3, 16'h0013);
        check_req("R2 busy req", 1'b1, 1'b0);
        eoi(4'd1, 8'h42);
        check_state("R6 wrong vector", 5'd3, 16'h0013);
        eoi(4'd1, 8'h41);
        check_state("R5 matching eoi", 5'd2, 16'h0011);
        eoi(4'd1, 8'h41);
        check_state("R6 duplicate eoi", 5'd2, 16'h0011);
        eoi(4'd5, 8'h41);
        check_state("R6 clear bit eoi", 5'd2, 16'h0011);
        deliver(16'hFF00, 8'h77, 6'd5);
        check_state("R4 busy delivery", 5'd2, 16'h0011);
        eoi(4'd0, 8'h41);
        eoi(4'd4, 8'h41);
        check_state("R5 all acked", 5'd0, 16'h0000);
        check_req("R2 free again", 1'b0, 1'b1);
    endtask

    task automatic t_negative();
        deliver(16'h0003, 8'h50, 6'h3F);
        check_state("R9 negative result", 5'd0, 16'h0000);
    endtask

    task automatic t_same_cycle();
        dlv_valid = 1; dlv_map = 16'h0100; dlv_vector = 8'h22; dlv_count = 6'd1;
        eoi_valid = 1; eoi_dest = 4'd8; eoi_vector = 8'h22;
        tick();
        dlv_valid = 0; eoi_valid = 0;
        check_state("R7 delivery wins", 5'd1, 16'h0100);
        eoi(4'd8, 8'h22);
        check_state("R7 later eoi", 5'd0, 16'h0000);
    endtask

    task automatic t_rebuild();
        deliver(16'h0006, 8'h30, 6'd1);
        check_state("R3 short count", 5'd1, 16'h0006);
        eoi(4'd1, 8'h30);
        check_state("R5 to zero", 5'd0, 16'h0004);
        live_pend = 16'h0009;
        eoi(4'd2, 8'h30);
        live_pend = '0;
        check_state("R8 rebuild", 5'd2, 16'h0009);
        eoi(4'd3, 8'h30);
        check_state("R8 rebuilt vector", 5'd1, 16'h0001);
    endtask

    task automatic t_saturate();
        do_reset();
        deliver(16'hFFFF, 8'h10, 6'd20);
        check_state("R9 saturate", 5'd16, 16'hFFFF);
        do_reset();
        check_state("R1 reset busy", 5'd0, 16'h0000);
    endtask

    initial begin
        idle();
        rst_n = 0;
        #2;
        t_reset();
        t_delivery_and_acks();
        t_negative();
        t_same_cycle();
        t_rebuild();
        t_saturate();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule